// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switchover Controller

This block picks one of two reference clocks and forwards it on a single output clock, moving between the two without ever producing a runt pulse. A switch is asked for on a request pin: only a low-to-high edge of that pin starts a switch. Each edge flips the chosen source, so repeated requests alternate between the two inputs. A flag output always names the input that is currently feeding the output.

The handover happens in two steps. First the old clock is gated off on one of its own falling edges. Then the new clock is gated on at a falling edge of the new clock. The output therefore stays low for a short gap and never carries a partial phase. Each input has a "bad" indicator. While the target clock is flagged bad, its gate is never opened: the controller holds the output low and waits, and it finishes the handover once the flag clears.

A small control state machine runs on the first clock and has three states. `ST_IDLE` waits for a request edge. Its transition *accept* (request edge seen) flips the selection and enters `ST_HOLD`. In `ST_HOLD` the request is still high and every further switch is blocked. The transition *release-done* (request low, handover already finished) returns to `ST_IDLE`. The transition *release-pending* (request low, handover not yet finished) goes to `ST_SETTLE`. `ST_SETTLE` ignores request edges until the transition *landed* (the active flag matches the selection) returns it to `ST_IDLE`.

Top module: `refclk_swap_ctrl`

## Requirements
- R1: After reset, `active_sel` reads 0 and `clk_out` follows `clk_a` with its period.
- R2: A rising edge of `swap_req` that is held high for at least three periods of the slower clock flips the source. Once the handover completes, `active_sel` has toggled and `clk_out` runs at the other input's period.
- R3: A falling edge of `swap_req` never causes a switch: `active_sel` and the output period are unchanged after the request is released.
- R4: While `swap_req` stays high, no further switch happens, and the selection stays stable for as long as the request is held.
- R5: Each source gate changes only while its own clock is low, and the two gates are never open at the same time.
- R6: `clk_out` never shows a high or low phase shorter than the shorter input half-period.
- R7: `active_sel` changes only when the new source's gate opens. During the gap it keeps the old value.
- R8: While the target clock's bad indicator (`bad_a` for `clk_a`, `bad_b` for `clk_b`) is high, its gate stays closed and `clk_out` stays low. When the indicator clears, the handover completes.
- R9: A rising edge of `swap_req` that arrives while a handover is still pending is ignored. The pending switch completes in its original direction.
- R10: Successive accepted requests alternate the source between `clk_a` (flag 0) and `clk_b` (flag 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First reference clock, selected after reset |
| clk_b | input | 1 | Second reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| swap_req | input | 1 | Switch request; a rising edge starts a switch |
| bad_a | input | 1 | High when `clk_a` must not be switched to |
| bad_b | input | 1 | High when `clk_b` must not be switched to |
| clk_out | output | 1 | Glitch-free muxed output clock |
| active_sel | output | 1 | 0 when `clk_a` drives the output, 1 when `clk_b` does |

## Verification
A phase monitor times every edge of the output. A gate that opened or closed while its clock was high, or two gates open together, would leave a sliver shorter than any input half-period. Holding the request high well past the handover catches a design that re-triggers on level instead of edge. Releasing it catches one that also reacts to the falling edge. With the target flagged bad, the bench checks that the output stays silent and the flag keeps its old value. A second request edge during that wait must not reverse the pending switch, which would happen in a design that accepts edges outside its idle state.

// File: rtl/refclk_swap_pkg.sv
package refclk_swap_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Control states of the switchover state machine
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // waiting for a request edge
        ST_HOLD   = 2'd1,  // request still high, further switches blocked
        ST_SETTLE = 2'd2   // request low, handover still in flight
    } swap_state_e;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/refclk_gate_chain.sv
// Falling-edge enable synchronizer for one clock source.
// tog flips in the same edge in which the enable opens.
module refclk_gate_chain #(
    parameter int STAGES = 2,
    parameter bit RST_ON = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    output logic en,
    output logic tog
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0] stg;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_ON}};
            tog <= 1'b0;
        end else begin
            stg <= {stg[STAGES-2:0], want};
            if (stg[STAGES-2] && !stg[STAGES-1]) begin
                tog <= ~tog;
            end
        end
    end

    assign en = stg[STAGES-1];
endmodule

// File: rtl/refclk_swap_fsm.sv
// Request edge detection and source selection, clocked by clk_a.
module refclk_swap_fsm
    import refclk_swap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    input  logic active_async,
    output logic sel,
    output logic req_sync
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [SYNC_STAGES-1:0] req_pipe;
    logic [SYNC_STAGES-1:0] act_pipe;
    logic                   req_last;
    logic                   act_sync;
    logic                   req_rise;
    swap_state_e            state, state_nx;
    logic                   sel_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_pipe <= '0;
            act_pipe <= '0;
            req_last <= 1'b0;
        end else begin
            req_pipe <= {req_pipe[SYNC_STAGES-2:0], req_async};
            act_pipe <= {act_pipe[SYNC_STAGES-2:0], active_async};
            req_last <= req_pipe[SYNC_STAGES-1];
        end
    end

    assign req_sync = req_pipe[SYNC_STAGES-1];
    assign act_sync = act_pipe[SYNC_STAGES-1];
    assign req_rise = req_sync && !req_last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= 1'b0;
        end else begin
            state <= state_nx;
            sel   <= sel_nx;
        end
    end

    // Next state and selection
    always_comb begin
        state_nx = state;
        sel_nx   = sel;
        unique case (state)
            ST_IDLE: begin
                if (req_rise) begin
                    state_nx = ST_HOLD;
                    sel_nx   = ~sel;
                end
            end
            ST_HOLD: begin
                if (!req_sync) begin
                    state_nx = (act_sync == sel) ? ST_IDLE : ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (act_sync == sel) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/refclk_swap_ctrl.sv
module refclk_swap_ctrl
    import refclk_swap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GATE_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic swap_req,
    input  logic bad_a,
    input  logic bad_b,
    output logic clk_out,
    output logic active_sel
);
    timeunit 1ns;
    timeprecision 1ps;

    logic               sel;
    logic               req_sync;
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] src_bad;
    logic [NUM_SRC-1:0] want;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] tog;

    assign src_clk = {clk_b, clk_a};
    assign src_bad = {bad_b, bad_a};

    refclk_swap_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk          (clk_a),
        .rst_n        (rst_n),
        .req_async    (swap_req),
        .active_async (active_sel),
        .sel          (sel),
        .req_sync     (req_sync)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam bit MINE = (i == 1);
        // Open only when chosen, the peer is closed, and (if not yet open) not bad
        assign want[i] = (sel == MINE) && !en[NUM_SRC-1-i] && (en[i] || !src_bad[i]);

        refclk_gate_chain #(
            .STAGES (GATE_STAGES),
            .RST_ON (i == 0)
        ) u_gate (
            .clk   (src_clk[i]),
            .rst_n (rst_n),
            .want  (want[i]),
            .en    (en[i]),
            .tog   (tog[i])
        );
    end

    assign clk_out    = |(src_clk & en);
    assign active_sel = tog[0] ^ tog[1];
endmodule

// File: rtl/refclk_swap_checker.sv
module refclk_swap_checker (
    input logic clk_a,
    input logic clk_b,
    input logic rst_n,
    input logic bad_a,
    input logic bad_b,
    input logic en_a,
    input logic en_b,
    input logic sel,
    input logic req_sync
);
    timeunit 1ns;
    timeprecision 1ps;

    AST_EN_EXCL: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(en_a && en_b)); // R5

    always @(en_a) begin
        if (rst_n) begin
            AST_EN_A_LOW_CHANGE: assert (!clk_a); // R5
        end
    end

    always @(en_b) begin
        if (rst_n) begin
            AST_EN_B_LOW_CHANGE: assert (!clk_b); // R5
        end
    end

    AST_BAD_B_BLOCKS: assert property (@(negedge clk_b) disable iff (!rst_n)
        ($past(bad_b) && !$past(en_b)) |=> !en_b); // R8

    AST_BAD_A_BLOCKS: assert property (@(negedge clk_a) disable iff (!rst_n)
        ($past(bad_a) && !$past(en_a)) |=> !en_a); // R8

    AST_HELD_NO_SWITCH: assert property (@(posedge clk_a) disable iff (!rst_n)
        (req_sync && $past(req_sync)) |=> $stable(sel)); // R4
endmodule

bind refclk_swap_ctrl refclk_swap_checker u_chk (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_n    (rst_n),
    .bad_a    (bad_a),
    .bad_b    (bad_b),
    .en_a     (en[0]),
    .en_b     (en[1]),
    .sel      (sel),
    .req_sync (req_sync)
);

// File: tb/refclk_swap_ctrl_tb_top.sv
module refclk_swap_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam real HALF_A  = 2.5;   // 200 MHz
    localparam real HALF_B  = 3.5;
    localparam real MIN_PH  = 2.4;   // shorter half-period less margin

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_n = 1'b0;
    logic swap_req = 1'b0;
    logic bad_a = 1'b0;
    logic bad_b = 1'b0;
    logic clk_out;
    logic active_sel;

    int  tests = 0;
    int  fails = 0;
    int  out_edges = 0;
    int  short_ph = 0;
    bit  mon_en = 1'b0;
    bit  have_last = 1'b0;
    bit  done = 1'b0;
    real last_t = 0.0;

    // Behavioural reference: selected source and pending handover
    int  exp_act = 0;
    bit  pending = 1'b0;

    always #(HALF_A) clk_a = ~clk_a;
    initial begin
        #1.0;
        forever #(HALF_B) clk_b = ~clk_b;
    end

    refclk_swap_ctrl dut_i (
        .clk_a      (clk_a),
        .clk_b      (clk_b),
        .rst_n      (rst_n),
        .swap_req   (swap_req),
        .bad_a      (bad_a),
        .bad_b      (bad_b),
        .clk_out    (clk_out),
        .active_sel (active_sel)
    );

    always @(posedge clk_out) out_edges++;

    // Phase monitor on every output transition (R5, R6)
    always @(clk_out) begin
        if (mon_en) begin
            if (have_last && ($realtime - last_t) < MIN_PH) short_ph++;
            last_t    = $realtime;
            have_last = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic check_active(input string req);
        check(active_sel == exp_act[0], req, "active_sel", real'(active_sel), real'(exp_act));
    endtask

    task automatic check_period(input string req);
        real t0, p, e;
        e = (exp_act == 0) ? 2.0 * HALF_A : 2.0 * HALF_B;
        @(posedge clk_out) t0 = $realtime;
        @(posedge clk_out) p = $realtime - t0;
        #0.3;
        check((p > e - 0.1) && (p < e + 0.1), req, "clk_out period", p, e);
    endtask

    // Request pulse; the model accepts it only when no handover is pending
    task automatic request(input real hold_ns);
        if (!pending) begin
            exp_act = 1 - exp_act;
            pending = 1'b1;
        end
        swap_req = 1'b1;
        #(hold_ns);
        swap_req = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #53.3 rst_n = 1'b1;
        mon_en = 1'b1;
        #100;
        check_active("R1");
        check_period("R1");

        // Long hold: handover completes while request is still high
        exp_act = 1; pending = 1'b1;
        swap_req = 1'b1;
        #300;
        check_active("R2");
        #300;
        check_active("R4");
        check_period("R2");
        swap_req = 1'b0; pending = 1'b0;
        #300;
        check_active("R3");
        check_period("R3");

        request(100.0);
        #300; pending = 1'b0;
        check_active("R10");
        check_period("R10");

        // Target flagged bad: output silent, flag unchanged, second edge ignored
        bad_b = 1'b1;
        #20;
        request(100.0);
        #300;
        begin
            int e0;
            e0 = out_edges;
            #200;
            check(out_edges == e0, "R8", "clk_out edges in wait", real'(out_edges - e0), 0.0);
            check(clk_out == 1'b0, "R8", "clk_out level in wait", real'(clk_out), 0.0);
        end
        check(active_sel == 1'b0, "R7", "active_sel during gap", real'(active_sel), 0.0);
        request(100.0);
        #200;
        check(active_sel == 1'b0, "R9", "active_sel still waiting", real'(active_sel), 0.0);
        bad_b = 1'b0;
        #300; pending = 1'b0;
        check_active("R9");
        check_period("R8");

        request(100.0);
        #300; pending = 1'b0;
        check_active("R10");
        check_period("R10");

        check(short_ph == 0, "R6", "short output phases", real'(short_ph), 0.0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule